// File: doc/BRIEF.md
# Flash Unlock-Bypass Command Decoder

This block sits behind the host side of a NOR-flash-style parallel bus and decodes command write cycles. It watches every host write (address, data, strobe) and follows the two-step unlock handshake. When that handshake is followed by the bypass-entry code, it moves into a persistent fast-program mode. In that mode a word is programmed with only two writes: a program code, then the target address and data. No unlock cycles are repeated between words. A two-write exit sequence returns the block to plain read mode.

Each accepted program operation becomes a one-cycle request that carries the target address and data. A small behavioural word array applies that request. Programming can only clear bits, so the stored word becomes the bitwise AND of the old and new values. The array has an asynchronous read port, so the effect of every program operation can be observed directly. The current mode is reported on a status output.

Top module: `flash_bypass_ctrl`

## Requirements
- R1: After reset the mode output is low (read mode), the program request is low, and every array word reads as all ones.
- R2: The writes AAh at address 555h, then 55h at address 2AAh, then 20h at any address set the mode output high. It becomes high in the cycle after the third write.
- R3: In the unlock handshake, a write whose address or data does not match the expected step returns the decoder to read mode. A later 20h write then does not enter bypass.
- R4: A third handshake write whose data is not 20h leaves the block in read mode.
- R5: In bypass mode, a write of A0h followed by a write of address A and data D raises the program request for one cycle. The pulse comes in the cycle after the second write, with A on the address output and D on the data output.
- R6: After a bypass program, further words can be programmed with only the A0h and address/data pair, with no unlock writes in between.
- R7: In bypass mode, a command-step write whose data is neither A0h nor 90h is ignored: no program request, and the mode stays high. A code matches only when the whole data word equals the code zero-extended, so 01A0h is not a program code.
- R8: In bypass mode, a write of 90h followed by a write of 00h sets the mode output low. The block is then in read mode.
- R9: In bypass mode, a 90h write followed by a non-zero write keeps bypass mode and returns to the command step. The next A0h then starts a program.
- R10: A program operation stores old AND new: a 1 written over a stored 0 leaves the 0.
- R11: The program request never stays high for two cycles in a row. The array word reads the new value one cycle after the request pulse.
- R12: In read mode, an A0h write followed by an address/data write does not program the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at rd_addr (combinational) |
| bypass_mode | output | 1 | High while in bypass mode |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address of the program request |
| prog_data | output | DATA_W | Data of the program request |

## Verification
The bench builds the block with an 11-bit address and a 16-bit data word. Eleven bits is the narrowest width that still holds both unlock addresses, and it keeps the whole 2048-word array inside the reset and read checks. The 16-bit word places non-zero bits above the 8-bit command codes. This makes it possible to show that a value such as 01A0h is not taken as a program code, and that program data wider than a byte merges bit by bit.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [2:0] {
    ST_READ     = 3'd0,
    ST_UNL1     = 3'd1,
    ST_UNL2     = 3'd2,
    ST_BYP      = 3'd3,
    ST_BYP_PGM  = 3'd4,
    ST_BYP_EXIT = 3'd5
  } dec_state_t;

  localparam logic [7:0]  CODE_UNL_A  = 8'hAA;
  localparam logic [7:0]  CODE_UNL_B  = 8'h55;
  localparam logic [7:0]  CODE_ENTER  = 8'h20;
  localparam logic [7:0]  CODE_PGM    = 8'hA0;
  localparam logic [7:0]  CODE_EXIT_A = 8'h90;
  localparam logic [7:0]  CODE_EXIT_B = 8'h00;
  localparam logic [11:0] UNL_ADDR_A  = 12'h555;
  localparam logic [11:0] UNL_ADDR_B  = 12'h2AA;

  function automatic logic in_bypass_state(dec_state_t s);
    return (s == ST_BYP) || (s == ST_BYP_PGM) || (s == ST_BYP_EXIT);
  endfunction

endpackage

// File: rtl/bypass_decoder.sv
module bypass_decoder
  import fbp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              in_bypass,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data
);

  function automatic logic data_is(logic [DATA_W-1:0] d, logic [7:0] code);
    return d == DATA_W'(code);
  endfunction

  function automatic logic addr_is(logic [ADDR_W-1:0] a, logic [11:0] ref_a);
    return {{(ADDR_W < 12 ? 12 - ADDR_W : 0){1'b0}}, a} == ref_a;
  endfunction

  dec_state_t state_q, state_d;

  logic hit_unl_a, hit_unl_b, hit_enter, hit_pgm, hit_exit_a, hit_exit_b;
  logic accept_pgm;

  assign hit_unl_a  = wr_en && addr_is(wr_addr, UNL_ADDR_A) && data_is(wr_data, CODE_UNL_A);
  assign hit_unl_b  = wr_en && addr_is(wr_addr, UNL_ADDR_B) && data_is(wr_data, CODE_UNL_B);
  assign hit_enter  = wr_en && data_is(wr_data, CODE_ENTER);
  assign hit_pgm    = wr_en && data_is(wr_data, CODE_PGM);
  assign hit_exit_a = wr_en && data_is(wr_data, CODE_EXIT_A);
  assign hit_exit_b = wr_en && data_is(wr_data, CODE_EXIT_B);
  assign accept_pgm = wr_en && (state_q == ST_BYP_PGM);

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      unique case (state_q)
        ST_READ:     state_d = hit_unl_a ? ST_UNL1 : ST_READ;
        ST_UNL1:     state_d = hit_unl_b ? ST_UNL2 : ST_READ;
        ST_UNL2:     state_d = hit_enter ? ST_BYP  : ST_READ;
        ST_BYP: begin
          if (hit_pgm)         state_d = ST_BYP_PGM;
          else if (hit_exit_a) state_d = ST_BYP_EXIT;
          else                 state_d = ST_BYP;
        end
        ST_BYP_PGM:  state_d = ST_BYP;
        ST_BYP_EXIT: state_d = hit_exit_b ? ST_READ : ST_BYP;
        default:     state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_READ;
      pgm_req  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
    end else begin
      state_q <= state_d;
      pgm_req <= accept_pgm;
      if (accept_pgm) begin
        pgm_addr <= wr_addr;
        pgm_data <= wr_data;
      end
    end
  end

  assign in_bypass = in_bypass_state(state_q);

  // R11: a request is never followed directly by another
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);

  // R5: a request always follows a host write
  a_r5_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> $past(wr_en));

  // R12: requests only appear while in bypass mode
  a_r12_req_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> (in_bypass && $past(in_bypass)));

  // R2: entry only through the entry code
  a_r2_entry_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_bypass) |-> $past(wr_en && data_is(wr_data, CODE_ENTER)));

  // R8: exit only through a zero write
  a_r8_exit_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_bypass) |-> $past(wr_en && data_is(wr_data, CODE_EXIT_B)));

  // R7: mode cannot change without a write
  a_r7_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(in_bypass));

endmodule

// File: rtl/word_array.sv
module word_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_en,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] merge_prog(logic [DATA_W-1:0] old_w,
                                                   logic [DATA_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] next_word;

  assign cur_word  = mem[pgm_addr];
  assign next_word = merge_prog(cur_word, pgm_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (pgm_en) begin
      mem[pgm_addr] <= next_word;
    end
  end

  assign rd_data = mem[rd_addr];

  // R10: programming sets no bit that was clear before
  a_r10_no_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> ((mem[$past(pgm_addr)] & ~$past(cur_word)) == '0));

  // R10: every zero in the program data ends up stored
  a_r10_zeros_land: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> ((mem[$past(pgm_addr)] & ~$past(pgm_data)) == '0));

endmodule

// File: rtl/flash_bypass_ctrl.sv
module flash_bypass_ctrl #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              bypass_mode,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);

  bypass_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .in_bypass (bypass_mode),
    .pgm_req   (prog_req),
    .pgm_addr  (prog_addr),
    .pgm_data  (prog_data)
  );

  word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgm_en   (prog_req),
    .pgm_addr (prog_addr),
    .pgm_data (prog_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  // R1: no request while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> !prog_req && !bypass_mode);

endmodule

// File: tb/tb_flash_bypass_ctrl.sv
`timescale 1ns/100ps
module tb_flash_bypass_ctrl;

  localparam int AW = 11;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          bypass_mode, prog_req;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;

  always #2.5 clk = ~clk;

  flash_bypass_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bypass_mode(bypass_mode), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  int    n_checks = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 read,1 got first unlock,2 got second,
  // 3 bypass waiting for code,4 waiting for program word,5 waiting exit data
  int            m_st = 0;
  bit            m_req = 0;
  logic [AW-1:0] m_pa;
  logic [DW-1:0] m_pd;
  logic [DW-1:0] mem_m [int];

  function automatic logic [DW-1:0] mget(int a);
    return mem_m.exists(a) ? mem_m[a] : {DW{1'b1}};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_req = 0; mem_m.delete();
    end else begin
      if (m_req) mem_m[int'(m_pa)] = mget(int'(m_pa)) & m_pd;
      m_req = 0;
      if (wr_en) begin
        case (m_st)
          0: m_st = (wr_addr == 'h555 && wr_data == 'hAA) ? 1 : 0;
          1: m_st = (wr_addr == 'h2AA && wr_data == 'h55) ? 2 : 0;
          2: m_st = (wr_data == 'h20) ? 3 : 0;
          3: if (wr_data == 'hA0) m_st = 4; else if (wr_data == 'h90) m_st = 5;
          4: begin m_req = 1; m_pa = wr_addr; m_pd = wr_data; m_st = 3; end
          default: m_st = (wr_data == 0) ? 0 : 3;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check(bypass_mode == (m_st >= 3), cur_tag, "mode", bypass_mode, m_st >= 3);
      check(prog_req == m_req, cur_tag, "prog_req", prog_req, m_req);
      if (m_req) begin
        check(prog_addr == m_pa, cur_tag, "prog_addr", prog_addr, m_pa);
        check(prog_data == m_pd, cur_tag, "prog_data", prog_data, m_pd);
      end
      check(rd_data == mget(int'(rd_addr)), cur_tag, "rd_data", rd_data, mget(int'(rd_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock_enter();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h123, 'h20);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    check(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    idle(3);
    #1 check(prog_req == 0 && bypass_mode == 0, "R1", "reset outputs", {prog_req, bypass_mode}, 0);
    rst_n = 1'b1;
    rd_addr = 'h7FF;
    @(negedge clk); #1;
    check(rd_data == 16'hFFFF, "R1", "erased word", rd_data, 16'hFFFF);
    check(bypass_mode == 0, "R1", "read mode", bypass_mode, 0);

    cur_tag = "R3";
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'h20); idle(1);
    check(bypass_mode == 0, "R3", "bad second address", bypass_mode, 0);
    wr('h555, 'hAA); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h000, 'h20); idle(1);
    check(bypass_mode == 0, "R3", "repeated first unlock", bypass_mode, 0);
    wr('h554, 'hAA); wr('h2AA, 'h55); wr('h000, 'h20); idle(1);
    check(bypass_mode == 0, "R3", "bad first address", bypass_mode, 0);

    cur_tag = "R4";
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h30); idle(1);
    check(bypass_mode == 0, "R4", "wrong third code", bypass_mode, 0);

    cur_tag = "R12";
    rd_addr = 'h010;
    wr('h555, 'hA0); wr('h010, 'h1234); idle(2);
    check(rd_data == 16'hFFFF, "R12", "no program in read mode", rd_data, 16'hFFFF);

    cur_tag = "R2";
    unlock_enter();
    #1 check(bypass_mode == 1, "R2", "entered bypass", bypass_mode, 1);

    cur_tag = "R5";
    wr('h000, 'hA0);
    wr('h010, 'h1234);
    #1 check(prog_req == 1 && prog_addr == 'h010 && prog_data == 'h1234,
             "R5", "request fields", {prog_req, prog_addr, prog_data}, {1'b1, 11'h010, 16'h1234});
    @(negedge clk); #1;
    check(prog_req == 0, "R11", "pulse one cycle", prog_req, 0);
    check(rd_data == 16'h1234, "R11", "array updated", rd_data, 16'h1234);

    cur_tag = "R10";
    wr('h000, 'hA0); wr('h010, 'hFF0F); idle(2);
    check(rd_data == 16'h1204, "R10", "and merge", rd_data, 16'h1204);

    cur_tag = "R6";
    for (int k = 0; k < 4; k++) begin
      wr('h000, 'hA0); wr('h100 + k, 'h0F00 | k);
    end
    rd_addr = 'h103; idle(2);
    check(rd_data == 16'h0F03, "R6", "back-to-back words", rd_data, 16'h0F03);

    cur_tag = "R7";
    rd_addr = 'h020;
    wr('h555, 'hAA); wr('h020, 'h0000); wr('h000, 'h01A0); wr('h020, 'h0000); idle(2);
    check(bypass_mode == 1, "R7", "still bypass", bypass_mode, 1);
    check(rd_data == 16'hFFFF, "R7", "ignored writes", rd_data, 16'hFFFF);

    cur_tag = "R9";
    wr('h000, 'h90); wr('h000, 'h0005); idle(1);
    check(bypass_mode == 1, "R9", "exit aborted", bypass_mode, 1);
    wr('h000, 'hA0); wr('h020, 'h00F0); idle(2);
    check(rd_data == 16'h00F0, "R9", "program after abort", rd_data, 16'h00F0);

    cur_tag = "R8";
    wr('h000, 'h90); wr('h000, 'h0000);
    #1 check(bypass_mode == 0, "R8", "left bypass", bypass_mode, 0);
    wr('h000, 'hA0); wr('h020, 'h0000); idle(2);
    check(rd_data == 16'h00F0, "R8", "read mode after exit", rd_data, 16'h00F0);

    cur_tag = "R2";
    unlock_enter();
    cur_tag = "R10";
    wr('h000, 'hA0); wr('h020, 'hFFFF); idle(2);
    check(rd_data == 16'h00F0, "R10", "ones do not restore", rd_data, 16'h00F0);
    idle(2);
    finish_run();
  end

endmodule